// File: doc/BRIEF.md
# Selectable-Rate Interpolation Chain

This block sits at the front of a transmit converter datapath. It takes 16-bit samples in offset-binary or two's-complement form, turns them into two's complement, and raises the sample rate by 1, 2, 4 or 8. It does this with a fixed cascade of three half-band stages. Each stage doubles the rate. A lower factor is reached by leaving the later stages out of the path.

The block runs on one clock at the output sample rate. It pulses `in_take` whenever it accepts a new input sample, and the source must present that sample on `in_data` in the same cycle. A stage that is out of the path gets no enable strobes, so its registers stay frozen. When the rate select changes, a one-cycle flush clears every register in the chain before the new rate begins.

Top module: `usc_interp`

## Requirements
- R1: While reset is held, and after it is released, `out_data` reads 0 until a sample has passed through the chain.
- R2: With `fmt_offset` = 1, the accepted sample has its bit 15 inverted (offset binary to two's complement). With `fmt_offset` = 0, the sample passes unchanged.
- R3: `rate_sel` encodes the factor as 0 = 1x (no stage), 1 = 2x, 2 = 4x and 3 = 8x. Outside a flush, `in_take` pulses exactly once every 1, 2, 4 or 8 cycles respectively.
- R4: At 1x, `out_data` shows the converted sample one clock after that sample was accepted.
- R5: A constant input appears unchanged on `out_data`, on every output cycle, once the pipeline has filled, in all four modes. Each stage's taps sum to 2^SHIFT and it rounds at bit SHIFT-1, so DC passes exactly, including at both ends of the 16-bit range.
- R6: Any stage result beyond the signed 16-bit range is clipped to 32767 or -32768 and never wraps.
- R7: A stage beyond the selected count receives no enable, and its output register holds its value.
- R8: A change of `rate_sel` causes a one-cycle flush. During that cycle `in_take` is low, and all delay lines, stage outputs and the sample register are cleared, so `out_data` reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 16 | Input sample, sampled when `in_take` is high |
| fmt_offset | input | 1 | 1 = input is offset binary, 0 = two's complement |
| rate_sel | input | 2 | Interpolation factor select (0:1x, 1:2x, 2:4x, 3:8x) |
| in_take | output | 1 | High in the cycle the block accepts `in_data` |
| out_data | output | 16 | Two's-complement output at the clock rate |

## Verification
On every cycle, the checker enforces the spacing of `in_take` pulses, the one-cycle path at 1x, the zeroed output and absent take strobe around a flush, and the frozen outputs of stages beyond the selected count. Exact DC gain in each mode, clean clipping on a full-scale step and the in_take counts per window depend on whole scenarios. So do format conversion across modes and the zeroed output after a rate change. Only the bench's directed scenarios show these.

// File: rtl/usc_pkg.sv
// Shared constants and tap tables for the interpolation chain.
// Assumes three stages; each stage's taps sum to 2^(SHIFT-1) per half.
package usc_pkg;
    localparam int W      = 16;
    localparam int NSTAGE = 3;
    localparam int ACCW   = 40;
    localparam int RSW    = $clog2(NSTAGE + 1);

    // Number of symmetric tap pairs in a stage (stage 0 is the first).
    function automatic int stage_pairs(input int stg);
        case (stg)
            0:       return 6;
            1:       return 5;
            default: return 2;
        endcase
    endfunction

    // Rounding / scaling shift of a stage.
    function automatic int stage_shift(input int stg);
        case (stg)
            0:       return 14;
            1:       return 13;
            default: return 11;
        endcase
    endfunction

    // Coefficient of pair idx (0 = outermost pair).
    function automatic int coef(input int stg, input int idx);
        if (stg == 0) begin
            case (idx)
                0: return -10;
                1: return 50;
                2: return -180;
                3: return 520;
                4: return -1400;
                default: return 9212;
            endcase
        end else if (stg == 1) begin
            case (idx)
                0: return 18;
                1: return -120;
                2: return 428;
                3: return -1294;
                default: return 5064;
            endcase
        end else begin
            case (idx)
                0: return -136;
                default: return 1160;
            endcase
        end
    endfunction
endpackage

// File: rtl/usc_format.sv
// Input sample register with format conversion.
// Loads on take; inverts the MSB for offset-binary input; clr empties it.
module usc_format #(
    parameter int W = usc_pkg::W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         take,
    input  logic         fmt_offset,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Capture and convert the accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            dout <= '0;
        else if (take)
            dout <= {din[W-1] ^ fmt_offset, din[W-2:0]};
    end
endmodule

// File: rtl/usc_strobes.sv
// Rate control: registers the rate select, raises a one-cycle flush on
// change, and derives per-stage input/output strobes from a free counter.
// Assumes the final active stage outputs every cycle.
module usc_strobes #(
    parameter int NSTAGE = usc_pkg::NSTAGE,
    parameter int RSW    = usc_pkg::RSW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSW-1:0]    rate_sel,
    output logic [RSW-1:0]    rate_q,
    output logic              flush,
    output logic              take,
    output logic [NSTAGE-1:0] stg_in_en,
    output logic [NSTAGE-1:0] stg_out_en
);
    logic [NSTAGE-1:0] cnt;
    logic [NSTAGE:0]   sub;   // sub[j]: cycle on which rate/2^j strobe fires
    int                nact;

    assign flush = (rate_sel != rate_q);
    assign nact  = int'(rate_q);

    // Hold the active rate and the phase counter; both restart on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rate_q <= rate_sel;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Sub-rate strobes: low j counter bits all ones.
    always_comb begin
        sub[0] = 1'b1;
        for (int j = 1; j <= NSTAGE; j++)
            sub[j] = sub[j-1] & cnt[j-1];
    end

    // Per-stage enables: active stages only, none during flush.
    always_comb begin
        take = !flush && sub[nact];
        for (int k = 0; k < NSTAGE; k++) begin
            if (k < nact && !flush) begin
                stg_in_en[k]  = sub[nact-k];
                stg_out_en[k] = sub[nact-k-1];
            end else begin
                stg_in_en[k]  = 1'b0;
                stg_out_en[k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/usc_halfband.sv
// One 2x half-band interpolation stage in polyphase form.
// Even output phase: centre tap (pure delay). Odd phase: symmetric
// pre-add filter, rounded at SHIFT-1, shifted and clipped to W bits.
// Assumes out_en fires twice per in_en and coincides with it once.
module usc_halfband #(
    parameter int STAGE = 0,
    parameter int W     = usc_pkg::W,
    parameter int ACCW  = usc_pkg::ACCW,
    parameter int NPAIR = usc_pkg::stage_pairs(STAGE),
    parameter int SHIFT = usc_pkg::stage_shift(STAGE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_en,
    input  logic                out_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int NTAP = 2 * NPAIR;
    localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (W-1)) - 1);
    localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;
    localparam logic signed [ACCW-1:0] RND  = ACCW'(64'sd1 <<< (SHIFT-1));

    logic signed [W-1:0]    tap [NTAP];
    logic                   phase;
    logic signed [ACCW-1:0] acc, scaled;
    logic signed [W-1:0]    filt;

    // Symmetric pre-add, multiply, round, scale and clip.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NPAIR; i++)
            acc = acc + ACCW'(usc_pkg::coef(STAGE, i)) *
                        (ACCW'(tap[i]) + ACCW'(tap[NTAP-1-i]));
        scaled = (acc + RND) >>> SHIFT;
        if (scaled > MAXV)
            filt = MAXV[W-1:0];
        else if (scaled < MINV)
            filt = MINV[W-1:0];
        else
            filt = scaled[W-1:0];
    end

    // Delay line shift, phase toggle and output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NTAP; i++) tap[i] <= '0;
            phase <= 1'b0;
            dout  <= '0;
        end else begin
            if (in_en) begin
                tap[0] <= din;
                for (int i = 1; i < NTAP; i++) tap[i] <= tap[i-1];
            end
            if (out_en) begin
                phase <= ~phase;
                dout  <= phase ? filt : tap[NPAIR-1];
            end
        end
    end
endmodule

// File: rtl/usc_interp.sv
// Top of the selectable-rate interpolation chain: format register,
// strobe generator and a cascade of half-band stages; the output is
// taken after the last selected stage. Assumes clk is the output rate.
module usc_interp #(
    parameter int W      = usc_pkg::W,
    parameter int NSTAGE = usc_pkg::NSTAGE,
    parameter int RSW    = usc_pkg::RSW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   in_data,
    input  logic           fmt_offset,
    input  logic [RSW-1:0] rate_sel,
    output logic           in_take,
    output logic [W-1:0]   out_data
);
    logic [RSW-1:0]            rate_q;
    logic                      flush;
    logic [NSTAGE-1:0]         stg_in_en, stg_out_en;
    logic [W-1:0]              fmt_q;
    logic [NSTAGE-1:0][W-1:0]  stg_y;

    usc_strobes #(.NSTAGE(NSTAGE), .RSW(RSW)) u_strobes (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rate_q(rate_q),
        .flush(flush), .take(in_take),
        .stg_in_en(stg_in_en), .stg_out_en(stg_out_en)
    );

    usc_format #(.W(W)) u_format (
        .clk(clk), .rst_n(rst_n), .clr(flush), .take(in_take),
        .fmt_offset(fmt_offset), .din(in_data), .dout(fmt_q)
    );

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        logic [W-1:0] stg_din;
        if (k == 0) begin : g_first
            assign stg_din = fmt_q;
        end else begin : g_next
            assign stg_din = stg_y[k-1];
        end
        usc_halfband #(.STAGE(k), .W(W)) u_hb (
            .clk(clk), .rst_n(rst_n), .clr(flush),
            .in_en(stg_in_en[k]), .out_en(stg_out_en[k]),
            .din(stg_din), .dout(stg_y[k])
        );
    end

    // Output tap point: formatter at 1x, otherwise last selected stage.
    always_comb begin
        out_data = fmt_q;
        for (int k = 0; k < NSTAGE; k++)
            if (int'(rate_q) == k + 1) out_data = stg_y[k];
    end
endmodule

// File: rtl/usc_interp_chk.sv
// Assertion checker for usc_interp, attached with bind.
module usc_interp_chk #(
    parameter int W      = usc_pkg::W,
    parameter int NSTAGE = usc_pkg::NSTAGE,
    parameter int RSW    = usc_pkg::RSW
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [W-1:0]             in_data,
    input logic                     fmt_offset,
    input logic                     in_take,
    input logic [W-1:0]             out_data,
    input logic [RSW-1:0]           rate_q,
    input logic                     flush,
    input logic [NSTAGE-1:0][W-1:0] stg_y
);
    a_r3_take_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && rate_q != '0) |=> !in_take);

    a_r4_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rate_q == '0) |=> out_data == $past(in_data ^ {fmt_offset, {(W-1){1'b0}}}));

    a_r8_flush_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_take);

    a_r8_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> out_data == '0);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_idle
        a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rate_q <= RSW'(k) && !flush) |=> $stable(stg_y[k]));
    end
endmodule

bind usc_interp usc_interp_chk #(.W(W), .NSTAGE(NSTAGE), .RSW(RSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .fmt_offset(fmt_offset),
    .in_take(in_take), .out_data(out_data), .rate_q(rate_q),
    .flush(flush), .stg_y(stg_y)
);

// File: tb/usc_interp_test.sv
// Directed bench for usc_interp: one task per scenario.
module usc_interp_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        fmt_offset = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic        in_take;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    usc_interp uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .fmt_offset(fmt_offset),
        .rate_sel(rate_sel), .in_take(in_take), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_rate(input int r);
        @(negedge clk);
        rate_sel = 2'(r);
        cycles(2);
    endtask

    // R1: output is zero out of reset.
    task automatic t_reset();
        cycles(3);
        check(out_data == 16'h0, "R1 in reset", int'(out_data), 0);
        rst_n = 1'b1;
        cycles(2);
        check(out_data == 16'h0, "R1 after reset", int'(out_data), 0);
    endtask

    // R4 and R2: one-cycle path at 1x, with both formats.
    task automatic t_bypass();
        set_rate(0);
        fmt_offset = 1'b0; in_data = 16'h1234;
        cycles(1);
        check(out_data == 16'h1234, "R4 1x one-cycle path", int'(out_data), 'h1234);
        fmt_offset = 1'b1; in_data = 16'h8000;
        cycles(1);
        check(out_data == 16'h0000, "R2 offset mid-scale", int'(out_data), 0);
        in_data = 16'h0000;
        cycles(1);
        check(out_data == 16'h8000, "R2 offset zero", int'(out_data), 'h8000);
        fmt_offset = 1'b0; in_data = 16'h8000;
        cycles(1);
        check(out_data == 16'h8000, "R2 twos passthrough", int'(out_data), 'h8000);
    endtask

    // R5: DC passes exactly on every output cycle after the fill.
    task automatic t_dc(input int r, input logic [15:0] v, input logic fmt, input logic [15:0] exp);
        bit ok = 1'b1;
        logic [15:0] bad = exp;
        set_rate(r);
        fmt_offset = fmt; in_data = v;
        cycles(300);
        for (int i = 0; i < 16; i++) begin
            if (out_data != exp) begin ok = 1'b0; bad = out_data; end
            cycles(1);
        end
        check(ok, $sformatf("R5 DC mode %0d", r), int'(bad), int'(exp));
    endtask

    // R3: in_take count over a 64-cycle window.
    task automatic t_cadence(input int r);
        int n = 0;
        set_rate(r);
        cycles(5);
        for (int i = 0; i < 64; i++) begin
            if (in_take) n++;
            cycles(1);
        end
        check(n == (64 >> r), $sformatf("R3 take count mode %0d", r), n, 64 >> r);
    endtask

    // R8: rate change flushes; no take in flush, zero output after.
    task automatic t_flush();
        t_dc(3, 16'd1000, 1'b0, 16'd1000);
        @(negedge clk);
        rate_sel = 2'd2;
        #1;
        check(in_take == 1'b0, "R8 no take during flush", int'(in_take), 0);
        @(negedge clk);
        check(out_data == 16'h0, "R8 cleared after flush", int'(out_data), 0);
    endtask

    // R7: with only stage 1 in use, later stages idle and 2x DC stays exact.
    task automatic t_idle();
        t_dc(1, 16'd500, 1'b0, 16'd500);
        check(out_data == 16'd500, "R7 2x with idle later stages", int'(out_data), 500);
    endtask

    // R6: full-scale step at 2x overshoots; result must clip, not wrap.
    task automatic t_clip();
        bit seen_hi = 1'b0;
        bit wrapped = 1'b0;
        logic [15:0] bad = '0;
        t_dc(1, 16'h8000, 1'b0, 16'h8000);
        in_data = 16'h7FFF;
        for (int i = 0; i < 120; i++) begin
            cycles(1);
            if ($signed(out_data) >= 16384) seen_hi = 1'b1;
            else if (seen_hi && $signed(out_data) < 0) begin wrapped = 1'b1; bad = out_data; end
        end
        check(seen_hi && !wrapped, "R6 no wrap on step", int'($signed(bad)), 32767);
        check(out_data == 16'h7FFF, "R6 settles at max", int'(out_data), 32767);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_dc(0, 16'd1000, 1'b0, 16'd1000);
        t_dc(1, 16'hFDFB, 1'b0, 16'hFDFB);
        t_dc(2, 16'hC000, 1'b1, 16'h4000);
        t_dc(3, 16'h8000, 1'b0, 16'h8000);
        t_dc(3, 16'h7FFF, 1'b0, 16'h7FFF);
        for (int r = 0; r < 4; r++) t_cadence(r);
        t_flush();
        t_idle();
        t_clip();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule